// File: doc/BRIEF.md
# Extended-precision to double-precision converter

This block turns an 80-bit extended-precision floating-point word into a 64-bit IEEE binary64 word. The input word has three fields: a sign bit at bit 79, a 15-bit exponent biased by 16383 at bits 78:64, and a 64-bit significand at bits 63:0. The top bit of the significand (bit 63) is an explicit integer bit. In binary64 that bit is hidden. The block sorts the input into one of five kinds: zero, finite, infinity, NaN or malformed. It moves the exponent to the binary64 bias of 1023 and drops the integer bit. It then rounds the 63 fraction bits to 52 with round-to-nearest-even.

Results that are too large saturate to infinity. Results that are too small go through gradual underflow to binary64 subnormals and then to zero. An encoding whose integer bit contradicts its exponent is malformed. It produces a quiet NaN and raises a flag. The block is a two-stage pipeline that accepts one word per cycle. An upstream datapath uses it to narrow extended intermediates before storing them.

Top module: `ext80_to_f64`

## Requirements
- R1: A word presented with `in_vld` high appears on `out_d` with `out_vld` high exactly two clock cycles later. Back-to-back inputs give back-to-back outputs in the same order, and `out_vld` stays low when no input was given.
- R2: A finite input (exponent 1..32766, bit 63 set) whose rebiased exponent E = exponent - 15360 lies in 1..2046 gives sign = bit 79, exponent field = E, fraction = significand bits 62:11. This holds when bits 10:0 are zero. The output sign always equals the input sign.
- R3: For the dropped bits 10:0, bit 10 is the guard and any set bit in 9:0 makes the sum sticky. The fraction is incremented when guard is set and either sticky or fraction bit 0 is set. A carry out of the fraction increments the exponent field.
- R4: A finite input with E >= 2047, or one whose rounding carries the exponent field to 2047, gives signed infinity (exponent field all ones, fraction zero) with `out_inv` low.
- R5: A finite input with E in -52..0 gives a subnormal result. The fraction is the 64-bit significand shifted right by 12 - E, rounded with the rules of R3. A carry out of bit 51 yields the smallest normal number.
- R6: A finite input with E below -52, a zero input, and an input with exponent 0 and bit 63 clear all give signed zero with `out_inv` low.
- R7: Exponent 32767 with bit 63 set and bits 62:0 zero gives signed infinity with `out_inv` low.
- R8: Exponent 32767 with bit 63 set and bits 62:0 nonzero gives a quiet NaN: exponent all ones, fraction 0x8000000000000, input sign, `out_inv` low.
- R9: Exponent 0 with bit 63 set, or a nonzero exponent with bit 63 clear (including exponent 32767 with a zero significand), gives the quiet NaN of R8 with the input sign and `out_inv` high.
- R10: After reset, `out_vld` is low until an input has been presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input word is valid this cycle |
| in_x | input | 80 | Extended word: sign, 15-bit exponent, 64-bit significand |
| out_vld | output | 1 | Result is valid this cycle |
| out_d | output | 64 | binary64 result |
| out_inv | output | 1 | Input was a malformed encoding |

## Verification
The hardest region to reach is the edge between subnormal results and zero. Here a shift of exactly 53 leaves only the guard bit, so the rounding outcome rests on an exact tie against a sticky bit. The stimulus picks exponents 15360 - 51, 15360 - 52 and 15360 - 53 with significands of a single leading one, a leading one plus a trailing one, and all ones. This reaches the tie, the round-up to the smallest subnormal and the flush to zero at the ports. The carries from an all-ones significand into the next exponent are driven the same way: into 2.0, into the smallest normal and into infinity.

// File: rtl/e2d_pkg.sv
package e2d_pkg;
  localparam int X_EXP_W  = 15;
  localparam int X_SIG_W  = 64;
  localparam int X_FRAC_W = X_SIG_W - 1;
  localparam int X_W      = 1 + X_EXP_W + X_SIG_W;
  localparam int D_EXP_W  = 11;
  localparam int D_FRAC_W = 52;
  localparam int D_W      = 1 + D_EXP_W + D_FRAC_W;
  localparam int MAG_W    = D_EXP_W + D_FRAC_W;
  localparam int X_BIAS   = 2 ** (X_EXP_W - 1) - 1;
  localparam int D_BIAS   = 2 ** (D_EXP_W - 1) - 1;
  localparam int BIAS_DIFF = X_BIAS - D_BIAS;
  localparam int DROP_W   = X_FRAC_W - D_FRAC_W;
  localparam int WEXP_W   = X_EXP_W + 2;
  localparam int SH_W     = $clog2(X_SIG_W + 1);

  localparam logic [MAG_W-1:0] INF_MAG  = {{D_EXP_W{1'b1}}, {D_FRAC_W{1'b0}}};
  localparam logic [MAG_W-1:0] QNAN_MAG = {{D_EXP_W{1'b1}}, 1'b1, {(D_FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {
    K_ZERO, K_FINITE, K_INF, K_QNAN, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e                     kind;
    logic                      sgn;
    logic signed [WEXP_W-1:0]  rexp;
    logic [X_SIG_W-1:0]        sig;
  } cls_t;
endpackage

// File: rtl/e2d_classify.sv
module e2d_classify
  import e2d_pkg::*;
(
  input  logic [X_W-1:0] x,
  output cls_t           c
);
  localparam logic signed [WEXP_W-1:0] BIAS_DIFF_W = WEXP_W'(BIAS_DIFF);

  logic               sgn;
  logic [X_EXP_W-1:0] ex;
  logic [X_SIG_W-1:0] sig;
  logic               ibit;
  logic               frac_nz;
  logic               exp_zero;
  logic               exp_ones;

  assign sgn      = x[X_W-1];
  assign ex       = x[X_W-2 -: X_EXP_W];
  assign sig      = x[X_SIG_W-1:0];
  assign ibit     = sig[X_SIG_W-1];
  assign frac_nz  = |sig[X_FRAC_W-1:0];
  assign exp_zero = (ex == '0);
  assign exp_ones = (ex == '1);

  always_comb begin
    c.sgn  = sgn;
    c.sig  = sig;
    c.rexp = $signed({2'b00, ex}) - BIAS_DIFF_W;
    if (exp_zero) begin
      // Input denormals lie far below the narrow format's range.
      c.kind = ibit ? K_BAD : K_ZERO;
    end else if (exp_ones) begin
      if (!ibit)        c.kind = K_BAD;
      else if (frac_nz) c.kind = K_QNAN;
      else              c.kind = K_INF;
    end else begin
      c.kind = ibit ? K_FINITE : K_BAD;
    end
  end
endmodule

// File: rtl/e2d_rshift.sv
module e2d_rshift #(
  parameter int IN_W  = 64,
  parameter int SH_W  = 7,
  parameter int OUT_W = 52
) (
  input  logic [IN_W-1:0]  v,
  input  logic [SH_W-1:0]  amt,
  output logic [OUT_W-1:0] kept,
  output logic             guard,
  output logic             sticky
);
  localparam int WIDE_W = 2 * IN_W;

  logic [WIDE_W-1:0] stg [SH_W+1];
  logic              unused_hi;

  assign stg[0] = {v, {IN_W{1'b0}}};

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stg[k+1] = amt[k] ? (stg[k] >> (2 ** k)) : stg[k];
  end

  assign kept      = stg[SH_W][IN_W +: OUT_W];
  assign guard     = stg[SH_W][IN_W-1];
  assign sticky    = |stg[SH_W][IN_W-2:0];
  assign unused_hi = ^stg[SH_W][WIDE_W-1:IN_W+OUT_W];
endmodule

// File: rtl/e2d_round.sv
module e2d_round
  import e2d_pkg::*;
(
  input  cls_t           c,
  output logic [D_W-1:0] y,
  output logic           bad
);
  localparam logic signed [WEXP_W-1:0] EXP_TOP   = WEXP_W'(2 ** D_EXP_W - 1);
  localparam logic signed [WEXP_W-1:0] EXP_MIN   = WEXP_W'(1);
  localparam logic signed [WEXP_W-1:0] EXP_FLOOR = WEXP_W'(-D_FRAC_W);
  localparam logic signed [WEXP_W-1:0] SH_BASE   = WEXP_W'(DROP_W + 1);

  // normal path
  logic [MAG_W-1:0] n_mag;
  logic             n_up;
  assign n_mag = {c.rexp[D_EXP_W-1:0], c.sig[X_FRAC_W-1 -: D_FRAC_W]};
  assign n_up  = c.sig[DROP_W-1] & ((|c.sig[DROP_W-2:0]) | c.sig[DROP_W]);

  // subnormal path
  logic signed [WEXP_W-1:0] tsh;
  logic [SH_W-1:0]          amt;
  logic [D_FRAC_W-1:0]      s_kept;
  logic                     s_g;
  logic                     s_s;
  logic                     s_up;
  logic                     unused_tsh;

  assign tsh        = SH_BASE - c.rexp;
  assign amt        = tsh[SH_W-1:0];
  assign unused_tsh = ^tsh[WEXP_W-1:SH_W];

  e2d_rshift #(
    .IN_W (X_SIG_W),
    .SH_W (SH_W),
    .OUT_W(D_FRAC_W)
  ) i_rshift (
    .v     (c.sig),
    .amt   (amt),
    .kept  (s_kept),
    .guard (s_g),
    .sticky(s_s)
  );

  assign s_up = s_g & (s_s | s_kept[0]);

  always_comb begin
    bad = 1'b0;
    y   = {c.sgn, {MAG_W{1'b0}}};
    unique case (c.kind)
      K_ZERO:  y = {c.sgn, {MAG_W{1'b0}}};
      K_INF:   y = {c.sgn, INF_MAG};
      K_QNAN:  y = {c.sgn, QNAN_MAG};
      K_BAD: begin
        y   = {c.sgn, QNAN_MAG};
        bad = 1'b1;
      end
      K_FINITE: begin
        if (c.rexp >= EXP_TOP) begin
          y = {c.sgn, INF_MAG};
        end else if (c.rexp >= EXP_MIN) begin
          // a carry past the top fraction bit flows into the exponent
          y = {c.sgn, n_mag + MAG_W'(n_up)};
        end else if (c.rexp >= EXP_FLOOR) begin
          y = {c.sgn, {{D_EXP_W{1'b0}}, s_kept} + MAG_W'(s_up)};
        end else begin
          y = {c.sgn, {MAG_W{1'b0}}};
        end
      end
      default: y = {c.sgn, {MAG_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/ext80_to_f64.sv
module ext80_to_f64
  import e2d_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [X_W-1:0] in_x,
  output logic           out_vld,
  output logic [D_W-1:0] out_d,
  output logic           out_inv
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // stage 1: classify and rebias
  cls_t cls_now;
  cls_t s1_cls_d, s1_cls_q;
  logic s1_vld_d, s1_vld_q;

  e2d_classify i_classify (
    .x(in_x),
    .c(cls_now)
  );

  always_comb begin
    s1_vld_d = in_vld;
    s1_cls_d = in_vld ? cls_now : s1_cls_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) s1_vld_q <= 1'b0;
    else          s1_vld_q <= s1_vld_d;
  end

  always_ff @(posedge clk) begin
    s1_cls_q <= s1_cls_d;
  end

  // stage 2: round and pack
  logic [D_W-1:0] res_now;
  logic           bad_now;
  logic [D_W-1:0] out_d_d;
  logic           out_inv_d;
  logic           out_vld_d;

  e2d_round i_round (
    .c  (s1_cls_q),
    .y  (res_now),
    .bad(bad_now)
  );

  always_comb begin
    out_vld_d = s1_vld_q;
    out_d_d   = s1_vld_q ? res_now : out_d;
    out_inv_d = s1_vld_q ? bad_now : out_inv;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) out_vld <= 1'b0;
    else          out_vld <= out_vld_d;
  end

  always_ff @(posedge clk) begin
    out_d   <= out_d_d;
    out_inv <= out_inv_d;
  end

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 out_vld);  // R1
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 2));  // R1
  AST_SIGN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_d[D_W-1] == $past(in_x[X_W-1], 2));  // R2
  AST_BAD_GIVES_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_inv) |-> out_d[MAG_W-1:0] == QNAN_MAG);  // R9
  AST_TOP_EXP_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_d[MAG_W-1 -: D_EXP_W] == '1) |->
      (out_d[D_FRAC_W-1:0] == '0 || out_d[D_FRAC_W-1:0] == QNAN_MAG[D_FRAC_W-1:0]));  // R4
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_vld_q) |=> !out_vld);  // R10
endmodule

// File: tb/test_ext80_to_f64.sv
`timescale 1ns/1ps
module test_ext80_to_f64;
  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] INF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [79:0] in_x;
  logic        out_vld;
  logic [63:0] out_d;
  logic        out_inv;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ext80_to_f64 i_ext80_to_f64 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x),
    .out_vld(out_vld), .out_d(out_d), .out_inv(out_inv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [79:0] mk(logic s, logic [14:0] e, logic [63:0] m);
    return {s, e, m};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one word through the pipe, checked two cycles later
  task automatic conv(string tag, logic [79:0] x, logic [63:0] ed, logic ei);
    @(negedge clk);
    in_vld = 1'b1;
    in_x   = x;
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    chk({tag, " vld"}, {63'b0, out_vld}, 64'd1);
    chk({tag, " data"}, out_d, ed);
    chk({tag, " inv"}, {63'b0, out_inv}, {63'b0, ei});
  endtask

  task automatic t_reset;
    chk("R10 idle after reset", {63'b0, out_vld}, 64'd0);
  endtask

  task automatic t_latency;
    @(negedge clk); in_vld = 1'b1; in_x = mk(0, 15'h3FFF, ONE);
    @(negedge clk); in_x = mk(1, 15'h4000, ONE);
    chk("R1 not yet valid", {63'b0, out_vld}, 64'd0);
    @(negedge clk); in_x = mk(0, 15'h3FFF, 64'hC000_0000_0000_0000);
    chk("R1 first", {out_vld, out_d[62:0]}, {1'b1, 63'h3FF0_0000_0000_0000});
    @(negedge clk); in_vld = 1'b0;
    chk("R1 second", out_d, 64'hC000_0000_0000_0000);
    chk("R1 second vld", {63'b0, out_vld}, 64'd1);
    @(negedge clk);
    chk("R1 third", out_d, 64'h3FF8_0000_0000_0000);
    @(negedge clk);
    chk("R1 drains", {63'b0, out_vld}, 64'd0);
  endtask

  task automatic t_normal;
    conv("R2 one", mk(0, 15'h3FFF, ONE), 64'h3FF0_0000_0000_0000, 0);
    conv("R2 neg pattern", mk(1, 15'h4005, 64'hA5A5_A5A5_A5A5_A000),
         {1'b1, 11'h405, 52'h4B4B_4B4B_4B4B4}, 0);
    conv("R2 max exp", mk(0, 15'h43FE, ONE), 64'h7FE0_0000_0000_0000, 0);
    conv("R2 min exp", mk(0, 15'h3C01, ONE), 64'h0010_0000_0000_0000, 0);
  endtask

  task automatic t_round;
    conv("R3 tie even down", mk(0, 15'h3FFF, 64'h8000_0000_0000_0400), 64'h3FF0_0000_0000_0000, 0);
    conv("R3 tie odd up",    mk(0, 15'h3FFF, 64'h8000_0000_0000_0C00), 64'h3FF0_0000_0000_0002, 0);
    conv("R3 above half",    mk(0, 15'h3FFF, 64'h8000_0000_0000_0401), 64'h3FF0_0000_0000_0001, 0);
    conv("R3 below half",    mk(0, 15'h3FFF, 64'h8000_0000_0000_03FF), 64'h3FF0_0000_0000_0000, 0);
    conv("R3 carry to exp",  mk(0, 15'h3FFF, ALL), 64'h4000_0000_0000_0000, 0);
  endtask

  task automatic t_overflow;
    conv("R4 round to inf", mk(0, 15'h43FE, ALL), INF, 0);
    conv("R4 exp too big",  mk(1, 15'h43FF, ONE), {1'b1, INF[62:0]}, 0);
    conv("R4 largest exp",  mk(0, 15'h7FFE, ALL), INF, 0);
  endtask

  task automatic t_subnormal;
    conv("R5 half min normal", mk(0, 15'h3C00, ONE), 64'h0008_0000_0000_0000, 0);
    conv("R5 carry to normal", mk(0, 15'h3C00, ALL), 64'h0010_0000_0000_0000, 0);
    conv("R5 min subnormal",   mk(0, 15'h3BCD, ONE), 64'h0000_0000_0000_0001, 0);
    conv("R5 tie to zero",     mk(0, 15'h3BCC, ONE), 64'h0000_0000_0000_0000, 0);
    conv("R5 tie plus up",     mk(1, 15'h3BCC, 64'h8000_0000_0000_0001), 64'h8000_0000_0000_0001, 0);
  endtask

  task automatic t_zero;
    conv("R6 below window", mk(1, 15'h3BCB, ALL), 64'h8000_0000_0000_0000, 0);
    conv("R6 plain zero",   mk(0, 15'h0000, 64'h0), 64'h0, 0);
    conv("R6 input denorm", mk(1, 15'h0000, 64'h1), 64'h8000_0000_0000_0000, 0);
  endtask

  task automatic t_special;
    conv("R7 pos inf", mk(0, 15'h7FFF, ONE), INF, 0);
    conv("R7 neg inf", mk(1, 15'h7FFF, ONE), {1'b1, INF[62:0]}, 0);
    conv("R8 nan neg", mk(1, 15'h7FFF, 64'hC000_0000_0000_0000), {1'b1, QN[62:0]}, 0);
    conv("R8 nan low", mk(0, 15'h7FFF, 64'h8000_0000_0000_0001), QN, 0);
  endtask

  task automatic t_invalid;
    conv("R9 zero exp ibit", mk(0, 15'h0000, ONE), QN, 1);
    conv("R9 normal no ibit", mk(1, 15'h3FFF, 64'h4000_0000_0000_0000), {1'b1, QN[62:0]}, 1);
    conv("R9 ones exp zero sig", mk(0, 15'h7FFF, 64'h0), QN, 1);
    conv("R9 ones exp no ibit", mk(0, 15'h7FFF, 64'h4000_0000_0000_0000), QN, 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    in_vld = 1'b0;
    in_x   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latency();
    t_normal();
    t_round();
    t_overflow();
    t_subnormal();
    t_zero();
    t_special();
    t_invalid();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule